// File: doc/BRIEF.md
# Single-Cycle Five-Instruction 32-bit Core

This block is a small single-cycle 32-bit processor. In every clock cycle it fetches one instruction word from an instruction memory, decodes it, reads two operands from a 32-entry register file and carries out the instruction. All state changes happen at the next rising clock edge.

The core supports five operations:

- a word load;
- a word store;
- an add of a sign-extended immediate;
- a branch taken when two registers differ;
- a host-output move that loads an 8-bit output port.

Both memories sit outside the core and answer in the same cycle, with combinational read data. Any other encoding is treated as a no-op. There are no exceptions, no interrupts and no hazard logic.

The design is split into an instruction decoder, a register file, and a datapath that holds the program counter, the adders and the host register. A small top module connects them and gates the request outputs during reset.

Top module: `core_top`

## Requirements
- R1: While `rst_ni` is low the fetch address is 0x00001000, `host_o` is 0 and `dmem_req_valid_o` is 0, whatever instruction is presented. `imem_req_valid_o` is 1 in every cycle.
- R2: For every instruction other than a taken branch, the next fetch address is the current fetch address plus 4.
- R3: Opcode bits[31:26]=001001 writes register rt (bits[20:16]) with register rs (bits[25:21]) plus bits[15:0] sign-extended to 32 bits. It makes no memory request.
- R4: Opcode 100011 issues a read request (`dmem_req_valid_o`=1, `dmem_req_write_o`=0) at address rs + sext(imm). It writes the same-cycle response data into rt.
- R5: Opcode 101011 issues a write request (`dmem_req_write_o`=1) at address rs + sext(imm), with the data taken from register rt. It does not change the register file.
- R6: Opcode 000101 sets the next fetch address to PC+4+(sext(imm)<<2) when registers rs and rt differ, and to PC+4 when they are equal.
- R7: Register 0 always reads as zero, and writes addressed to it are discarded.
- R8: Opcode 010000 with bits[25:21]=00100 loads the low 8 bits of register rt into `host_o`. It makes no memory request and no register write. `host_o` keeps its value under every other instruction.
- R9: Any other encoding makes no memory request and changes neither the register file nor `host_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_req_valid_o | output | 1 | Fetch request valid, always 1 |
| imem_req_addr_o | output | 32 | Fetch address (program counter) |
| imem_resp_data_i | input | 32 | Instruction word for the current fetch address |
| dmem_req_valid_o | output | 1 | Data request valid |
| dmem_req_write_o | output | 1 | 1 = write request, 0 = read request |
| dmem_req_addr_o | output | 32 | Data byte address |
| dmem_req_wdata_o | output | 32 | Store data |
| dmem_resp_data_i | input | 32 | Load data returned in the same cycle |
| host_o | output | 8 | Host output register |

## Verification
A directed program comes first. It exercises register 0 as a write target and as a source, a negative immediate, taken and not-taken branches, a load followed by a host move, and an unrecognised opcode. This separates errors in field extraction, sign extension and the branch compare.

Several rounds of random 64-word programs follow. They are drawn from all six instruction classes over a small set of registers, so operands collide often. A reference interpreter in the bench predicts, cycle by cycle, the fetch address, the data request and `host_o`. Random backward branches form loops, which makes stale register values and wrong branch offsets show up quickly.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned RIDX_W = 5;

  localparam logic [5:0] OP_LD   = 6'b100011;
  localparam logic [5:0] OP_ST   = 6'b101011;
  localparam logic [5:0] OP_ADDI = 6'b001001;
  localparam logic [5:0] OP_BNE  = 6'b000101;
  localparam logic [5:0] OP_COP  = 6'b010000;
  localparam logic [4:0] COP_MV  = 5'b00100;

  localparam logic [31:0] PAT_LD   = {OP_LD,   26'bz};
  localparam logic [31:0] PAT_ST   = {OP_ST,   26'bz};
  localparam logic [31:0] PAT_ADDI = {OP_ADDI, 26'bz};
  localparam logic [31:0] PAT_BNE  = {OP_BNE,  26'bz};
  localparam logic [31:0] PAT_HOST = {OP_COP, COP_MV, 21'bz};

  typedef struct packed {
    logic br_ne;    // branch on operands differing
    logic wb_mem;   // write-back from load data
    logic rf_we;
    logic mem_val;
    logic mem_wr;
    logic host_en;
  } ctrl_t;
endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [31:0]       instr_i,
  output ctrl_t             ctrl_o,
  output logic [RIDX_W-1:0] rs_o,
  output logic [RIDX_W-1:0] rt_o,
  output logic [IMM_W-1:0]  imm_o
);
  assign rs_o  = instr_i[25:21];
  assign rt_o  = instr_i[20:16];
  assign imm_o = instr_i[15:0];

  always_comb begin
    ctrl_o = '0;
    casez (instr_i)
      PAT_ADDI: ctrl_o.rf_we = 1'b1;
      PAT_LD: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
        ctrl_o.mem_val = 1'b1;
      end
      PAT_ST: begin
        ctrl_o.mem_val = 1'b1;
        ctrl_o.mem_wr  = 1'b1;
      end
      PAT_BNE:  ctrl_o.br_ne   = 1'b1;
      PAT_HOST: ctrl_o.host_en = 1'b1;
      default:  ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra0_i,
  output logic [DW-1:0] rd0_o,
  input  logic [AW-1:0] ra1_i,
  output logic [DW-1:0] rd1_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs[g] <= '0;
        else if (we_i && wa_i == AW'(g)) regs[g] <= wd_i;
      end
    end
  end

  assign rd0_o = regs[ra0_i];
  assign rd1_o = regs[ra1_i];
endmodule

// File: rtl/core_dpath.sv
module core_dpath
  import core_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000,
  parameter int unsigned     HOST_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   rs_data_i,
  input  logic [XLEN-1:0]   rt_data_i,
  input  logic [XLEN-1:0]   ld_data_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   alu_o,
  output logic [XLEN-1:0]   wb_o,
  output logic [HOST_W-1:0] host_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] pc_q, pc_plus4, br_tgt, pc_d, sext;
  logic            take_br;

  assign sext     = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + (sext << 2);
  assign take_br  = ctrl_i.br_ne && (rs_data_i != rt_data_i);
  assign pc_d     = take_br ? br_tgt : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_d;
  end

  assign alu_o = rs_data_i + sext;
  assign wb_o  = ctrl_i.wb_mem ? ld_data_i : alu_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            host_o <= '0;
    else if (ctrl_i.host_en) host_o <= rt_data_i[HOST_W-1:0];
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/core_top.sv
module core_top
  import core_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_1000,
  parameter int unsigned NREG     = 32,
  parameter int unsigned HOST_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              imem_req_valid_o,
  output logic [31:0]       imem_req_addr_o,
  input  logic [31:0]       imem_resp_data_i,
  output logic              dmem_req_valid_o,
  output logic              dmem_req_write_o,
  output logic [31:0]       dmem_req_addr_o,
  output logic [31:0]       dmem_req_wdata_o,
  input  logic [31:0]       dmem_resp_data_i,
  output logic [HOST_W-1:0] host_o
);
  ctrl_t             ctrl;
  logic [RIDX_W-1:0] rs, rt;
  logic [IMM_W-1:0]  imm;
  logic [XLEN-1:0]   rs_data, rt_data, alu, wb;

  core_decode u_dec (
    .instr_i (imem_resp_data_i),
    .ctrl_o  (ctrl),
    .rs_o    (rs),
    .rt_o    (rt),
    .imm_o   (imm)
  );

  core_regfile #(.NREG(NREG), .DW(XLEN)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra0_i  (rs),
    .rd0_o  (rs_data),
    .ra1_i  (rt),
    .rd1_o  (rt_data),
    .we_i   (ctrl.rf_we & rst_ni),
    .wa_i   (rt),
    .wd_i   (wb)
  );

  core_dpath #(.RESET_PC(RESET_PC), .HOST_W(HOST_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl),
    .imm_i     (imm),
    .rs_data_i (rs_data),
    .rt_data_i (rt_data),
    .ld_data_i (dmem_resp_data_i),
    .pc_o      (imem_req_addr_o),
    .alu_o     (alu),
    .wb_o      (wb),
    .host_o    (host_o)
  );

  assign imem_req_valid_o = 1'b1;
  assign dmem_req_valid_o = ctrl.mem_val & rst_ni;
  assign dmem_req_write_o = ctrl.mem_wr;
  assign dmem_req_addr_o  = alu;
  assign dmem_req_wdata_o = rt_data;
endmodule

// File: rtl/core_chk.sv
module core_chk #(
  parameter int unsigned HOST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              imem_req_valid_o,
  input logic [31:0]       imem_req_addr_o,
  input logic [31:0]       imem_resp_data_i,
  input logic              dmem_req_valid_o,
  input logic [HOST_W-1:0] host_o
);
  logic [5:0] op;
  logic       is_bne, is_host, is_known;
  assign op       = imem_resp_data_i[31:26];
  assign is_bne   = (op == 6'b000101);
  assign is_host  = (op == 6'b010000) && (imem_resp_data_i[25:21] == 5'b00100);
  assign is_known = is_bne || is_host || op == 6'b100011 || op == 6'b101011 || op == 6'b001001;

  p_fetch_valid_r1: assert property (@(posedge clk_i) imem_req_valid_o);
  p_no_mem_in_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> !dmem_req_valid_o);
  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_bne |=> imem_req_addr_o == $past(imem_req_addr_o) + 32'd4);
  p_bne_same_reg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_bne && imem_resp_data_i[25:21] == imem_resp_data_i[20:16])
    |=> imem_req_addr_o == $past(imem_req_addr_o) + 32'd4);
  p_host_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_host |=> $stable(host_o));
  p_host_no_mem_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_host |-> !dmem_req_valid_o);
  p_unknown_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_known |-> !dmem_req_valid_o);
endmodule

bind core_top core_chk #(.HOST_W(HOST_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .imem_req_valid_o (imem_req_valid_o),
  .imem_req_addr_o  (imem_req_addr_o),
  .imem_resp_data_i (imem_resp_data_i),
  .dmem_req_valid_o (dmem_req_valid_o),
  .host_o           (host_o)
);

// File: tb/sim_core_top.sv
`timescale 1ns/1ps
module sim_core_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iv, dv, dw;
  logic [31:0] ia, idat, da, dwd, drd;
  logic [7:0]  host;

  logic [31:0] prog [64];
  logic [31:0] dmem [64];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign idat = prog[ia[7:2]];
  assign drd  = dmem[da[7:2]];

  core_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_req_valid_o(iv), .imem_req_addr_o(ia), .imem_resp_data_i(idat),
    .dmem_req_valid_o(dv), .dmem_req_write_o(dw), .dmem_req_addr_o(da),
    .dmem_req_wdata_o(dwd), .dmem_resp_data_i(drd), .host_o(host)
  );

  // reference interpreter state
  logic [31:0] m_pc;
  logic [31:0] m_rf [32];
  logic [7:0]  m_host;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_host(int rt);
    return {6'b010000, 5'b00100, 5'(rt), 16'h0000};
  endfunction

  task automatic model_reset();
    m_pc = 32'h0000_1000;
    m_host = 8'h00;
    for (int i = 0; i < 32; i++) m_rf[i] = 32'h0;
  endtask

  task automatic fill_dmem(int seed);
    for (int i = 0; i < 64; i++) dmem[i] = 32'h9e37_79b9 * (i + 1) + 32'(seed);
  endtask

  // compare outputs for the current cycle, then advance the model
  task automatic compare_and_step();
    logic [31:0] ins, a, b, sx, npc;
    logic [5:0]  op;
    int rs, rt;
    bit is_ld, is_st, is_add, is_bne, is_host;
    string tag;
    ins = prog[m_pc[7:2]];
    op = ins[31:26]; rs = int'(ins[25:21]); rt = int'(ins[20:16]);
    sx = {{16{ins[15]}}, ins[15:0]};
    a = (rs == 0) ? 32'h0 : m_rf[rs];
    b = (rt == 0) ? 32'h0 : m_rf[rt];
    is_ld = (op == 6'b100011); is_st = (op == 6'b101011); is_add = (op == 6'b001001);
    is_bne = (op == 6'b000101); is_host = (op == 6'b010000) && (rs == 4);
    tag = is_ld ? "R4" : is_st ? "R5" : is_add ? "R3" : is_bne ? "R6" : is_host ? "R8" : "R9";
    chk(is_bne ? "R6" : "R2", "fetch addr", ia, m_pc);
    chk("R1", "fetch valid", 32'(iv), 32'd1);
    chk(tag, "dmem valid", 32'(dv), 32'(is_ld || is_st));
    chk(tag, "host", 32'(host), 32'(m_host));
    if (is_ld || is_st) begin
      chk(tag, "dmem write", 32'(dw), 32'(is_st));
      chk(tag, "dmem addr", da, a + sx);
    end
    if (is_st) chk((rt == 0) ? "R7" : "R5", "store data", dwd, b);
    npc = m_pc + 32'd4;
    if (is_add && rt != 0) m_rf[rt] = a + sx;
    if (is_ld && rt != 0)  m_rf[rt] = dmem[5'(0) + (a + sx) >> 2 & 32'h3f];
    if (is_st)             dmem[(a + sx) >> 2 & 32'h3f] = b;
    if (is_bne && a != b)  npc = npc + (sx << 2);
    if (is_host)           m_host = b[7:0];
    m_pc = npc;
  endtask

  task automatic run(int seed, int cycles);
    rst_n = 1'b0;
    model_reset();
    fill_dmem(seed);
    repeat (3) begin
      @(negedge clk);
      chk("R1", "reset pc", ia, 32'h0000_1000);
      chk("R1", "reset dmem valid", 32'(dv), 32'd0);
      chk("R1", "reset host", 32'(host), 32'd0);
      chk("R1", "reset fetch valid", 32'(iv), 32'd1);
    end
    rst_n = 1'b1;
    repeat (cycles) begin
      #1;
      compare_and_step();
      @(negedge clk);
    end
  endtask

  task automatic load_directed();
    for (int i = 0; i < 64; i++) prog[i] = 32'hFC00_0000; // unknown opcode filler
    prog[0]  = enc_i(6'b101011, 0, 0, 16'h0000);  // store during reset: must be gated (R1)
    prog[1]  = enc_i(6'b001001, 0, 1, 16'd5);     // r1 = 5
    prog[2]  = enc_i(6'b001001, 0, 0, 16'd7);     // write to r0 dropped (R7)
    prog[3]  = enc_i(6'b101011, 0, 0, 16'd4);     // store r0 -> 0 (R7)
    prog[4]  = enc_i(6'b001001, 1, 2, 16'hFFFF);  // r2 = 4, negative imm
    prog[5]  = enc_i(6'b100011, 0, 3, 16'd8);     // r3 = mem[2]
    prog[6]  = enc_host(3);                       // host = r3[7:0]
    prog[7]  = enc_i(6'b000101, 1, 2, 16'd1);     // taken, skip 8
    prog[8]  = enc_i(6'b001001, 0, 4, 16'd99);
    prog[9]  = enc_i(6'b000101, 1, 1, 16'd5);     // not taken
    prog[10] = 32'hFFFF_FFFF;                     // unrecognised (R9)
    prog[11] = enc_i(6'b101011, 0, 4, 16'd12);    // r4 still 0
    prog[12] = enc_i(6'b000101, 0, 1, 16'hFFF3);  // back to index 0
  endtask

  task automatic load_random();
    for (int i = 0; i < 64; i++) begin
      int k = int'($urandom_range(0, 11));
      int rs = int'($urandom_range(0, 7));
      int rt = int'($urandom_range(0, 7));
      logic [15:0] imm = 16'($signed(int'($urandom_range(0, 63)) - 32));
      case (k)
        0, 1, 2: prog[i] = enc_i(6'b001001, rs, rt, imm);
        3, 4:    prog[i] = enc_i(6'b100011, rs, rt, imm);
        5, 6:    prog[i] = enc_i(6'b101011, rs, rt, imm);
        7, 8:    prog[i] = enc_i(6'b000101, rs, rt, 16'($signed(int'($urandom_range(0, 15)) - 8)));
        9:       prog[i] = enc_host(rt);
        10:      prog[i] = {6'b010000, 5'b00000, 5'(rt), 16'h0}; // near-miss host move
        default: prog[i] = $urandom();
      endcase
    end
  endtask

  initial begin
    load_directed();
    run(1, 200);
    for (int r = 0; r < 8; r++) begin
      load_random();
      run(r + 7, 400);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule